// File: doc/BRIEF.md
# Random Number Controller Register Interface

This block is the register-mapped front end of a hardware random number generator. Software reaches it through a small single-cycle register bus. Writing one-bits to a command register starts a self-test or a seeding operation. Each operation runs for a fixed number of clock cycles and then raises a done flag. A failed statistical test leaves an error code in an error register. Software clears these conditions with two clear commands, and each clear command acts differently depending on whether an error is recorded. A single interrupt pin reports done and error conditions, and a control register masks each source on its own.

After a successful seed, a deterministic xorshift generator stands in for the entropy source. It fills a 16-word output buffer at one word per cycle. Software pops words by reading the buffer port and watches the fill level in the status register. An input pin forces the statistical check to fail, so that the error paths can be reached.

The bus has no back-pressure and no wait states. A read returns data in the same cycle that the select is asserted, and a read of the buffer port pops the word it returns at the next clock edge. The generator is the only producer. It is throttled internally: it stops pushing while the buffer is full, while an operation runs, and while an error is recorded.

Top module: `rng_ctl`

## Requirements
- R1: After reset, every readable register reads 0, the buffer is empty and `irq` is low.
- R2: Registers sit at byte offsets command 0x04, control 0x08, status 0x0C, error 0x10 and buffer port 0x14. The command register always reads 0. Control bits 5 (done mask) and 6 (error mask) read back as written.
- R3: Command bits are write-one pulses: bit 0 starts a self-test and bit 1 starts a seed, and the self-test wins if both bits are set. The status done flag (bit 4 for a self-test, bit 5 for a seed) sets on the OP_CYCLES-th rising edge after the edge that captured the write.
- R4: Command bit 4 clears both done flags only when the error register is zero. Command bit 5 clears the error register and both done flags.
- R5: `irq` = ((status bit 4 or bit 5) and not control bit 5) or (error register nonzero and not control bit 6).
- R6: Status bits 11:8 show the buffer fill level, and they saturate at 15 when all 16 words are held.
- R7: Once a seed completes without error, the generator pushes one word per cycle until the buffer is full. It pushes nothing while the buffer is full.
- R8: Words leave the buffer in generation order. The k-th word is the k-th iterate of x ^= x<<13; x ^= x>>17; x ^= x<<5, starting from SEED_INIT (default 0x2545F491).
- R9: A read of the buffer port while the buffer is empty returns 0 and leaves the level at 0.
- R10: If `force_fail` is high when an operation completes, error bit 3 sets and status bit 16 goes high. A failed seed does not enable generation, and generation stalls while the error register is nonzero.
- R11: Start commands written while an operation is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_sel` |
| force_fail | input | 1 | Makes the completing operation report a statistical failure |
| irq | output | 1 | Masked done/error interrupt |

## Verification
The hardest state to reach is an error that coexists with a set done flag. In that state a clear-interrupt must change nothing, while a clear-error must drop everything. The bench holds `force_fail` across the completion edge of a seed to get there. It then walks the mask bits and both clear commands, and checks that the buffer stayed empty. Exact completion timing and the saturated level of 15 are reached by counting edges after a seed command and by letting the generator run with no reads.

// File: rtl/rng_ctl_pkg.sv
package rng_ctl_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CMD  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_ERR  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_BUF  = 5'h14;

  localparam int CMD_TEST_B  = 0;
  localparam int CMD_SEED_B  = 1;
  localparam int CMD_CLRI_B  = 4;
  localparam int CMD_CLRE_B  = 5;
  localparam int CTRL_MDONE_B = 5;
  localparam int CTRL_MERR_B  = 6;
  localparam int STAT_ERR_B   = 16;
  localparam int STAT_LVL_LO  = 8;
  localparam int STAT_SDONE_B = 5;
  localparam int STAT_TDONE_B = 4;
  localparam int ERR_STAT_B   = 3;

  function automatic logic [DATA_W-1:0] xs_step(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction
endpackage

// File: rtl/rng_seq.sv
module rng_seq #(
  parameter int OP_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_test,
  input  logic start_seed,
  input  logic force_fail,
  input  logic clr_int,
  input  logic clr_err,
  output logic busy,
  output logic test_done,
  output logic seed_done,
  output logic stat_err,
  output logic seeded
);
  localparam int CNT_W = (OP_CYCLES > 2) ? $clog2(OP_CYCLES) : 1;

  logic [CNT_W-1:0] cnt;
  logic             op_seed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      op_seed   <= 1'b0;
      test_done <= 1'b0;
      seed_done <= 1'b0;
      stat_err  <= 1'b0;
      seeded    <= 1'b0;
    end else begin
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          if (op_seed) seed_done <= 1'b1;
          else         test_done <= 1'b1;
          if (force_fail)   stat_err <= 1'b1;
          else if (op_seed) seeded   <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start_test || start_seed) begin
        busy    <= 1'b1;
        cnt     <= CNT_W'(OP_CYCLES - 1);
        op_seed <= !start_test;
      end
      // clears are evaluated last so they win over a same-cycle completion
      if (clr_err) begin
        stat_err  <= 1'b0;
        test_done <= 1'b0;
        seed_done <= 1'b0;
      end else if (clr_int && !stat_err) begin
        test_done <= 1'b0;
        seed_done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rng_prng.sv
module rng_prng
  import rng_ctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] SEED_INIT = 32'h2545F491
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] state;

  assign word = xs_step(state);

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED_INIT;
    else if (step) state <= word;
  end
endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rng_ctl.sv
module rng_ctl
  import rng_ctl_pkg::*;
#(
  parameter int                DEPTH     = 16,
  parameter int                OP_CYCLES = 64,
  parameter int                LVL_W     = 4,
  parameter logic [DATA_W-1:0] SEED_INIT = 32'h2545F491
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              force_fail,
  output logic              irq
);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  logic cmd_wr, ctrl_wr, buf_rd;
  logic mask_done, mask_err;
  logic busy, test_done, seed_done, stat_err, seeded;
  logic gen_push, buf_pop, buf_full, buf_empty;
  logic [DATA_W-1:0] gen_word, buf_head;
  logic [CNT_W-1:0]  fifo_count;
  logic [LVL_W-1:0]  level;
  logic [DATA_W-1:0] stat_word, err_word, ctrl_word;

  assign cmd_wr  = bus_sel && bus_wr && (bus_addr == OFS_CMD);
  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
  assign buf_rd  = bus_sel && !bus_wr && (bus_addr == OFS_BUF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_done <= 1'b0;
      mask_err  <= 1'b0;
    end else if (ctrl_wr) begin
      mask_done <= bus_wdata[CTRL_MDONE_B];
      mask_err  <= bus_wdata[CTRL_MERR_B];
    end
  end

  rng_seq #(.OP_CYCLES(OP_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_test (cmd_wr && bus_wdata[CMD_TEST_B]),
    .start_seed (cmd_wr && bus_wdata[CMD_SEED_B]),
    .force_fail (force_fail),
    .clr_int    (cmd_wr && bus_wdata[CMD_CLRI_B]),
    .clr_err    (cmd_wr && bus_wdata[CMD_CLRE_B]),
    .busy       (busy),
    .test_done  (test_done),
    .seed_done  (seed_done),
    .stat_err   (stat_err),
    .seeded     (seeded)
  );

  assign gen_push = seeded && !busy && !buf_full && !stat_err;
  assign buf_pop  = buf_rd && !buf_empty;

  rng_prng #(.SEED_INIT(SEED_INIT)) u_prng (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (gen_push),
    .word  (gen_word)
  );

  rng_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (gen_push),
    .wdata (gen_word),
    .pop   (buf_pop),
    .head  (buf_head),
    .count (fifo_count),
    .full  (buf_full),
    .empty (buf_empty)
  );

  // level field saturates when the count does not fit its width
  generate
    if (DEPTH > LVL_MAX) begin : g_lvl_sat
      assign level = (fifo_count > CNT_W'(LVL_MAX)) ? LVL_W'(LVL_MAX) : LVL_W'(fifo_count);
    end else begin : g_lvl_fit
      assign level = LVL_W'(fifo_count);
    end
  endgenerate

  always_comb begin
    stat_word = '0;
    stat_word[STAT_ERR_B]                       = stat_err;
    stat_word[STAT_LVL_LO +: LVL_W]             = level;
    stat_word[STAT_SDONE_B]                     = seed_done;
    stat_word[STAT_TDONE_B]                     = test_done;
    err_word  = '0;
    err_word[ERR_STAT_B]                        = stat_err;
    ctrl_word = '0;
    ctrl_word[CTRL_MDONE_B]                     = mask_done;
    ctrl_word[CTRL_MERR_B]                      = mask_err;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_CTRL: bus_rdata = ctrl_word;
        OFS_STAT: bus_rdata = stat_word;
        OFS_ERR:  bus_rdata = err_word;
        OFS_BUF:  bus_rdata = buf_empty ? '0 : buf_head;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign irq = ((test_done || seed_done) && !mask_done) || (stat_err && !mask_err);
endmodule

// File: rtl/rng_ctl_chk.sv
module rng_ctl_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [4:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             irq,
  input logic [CNT_W-1:0] fifo_count,
  input logic             busy,
  input logic             test_done,
  input logic             seed_done,
  input logic             stat_err,
  input logic             mask_done,
  input logic             mask_err
);
  logic cmd_w, rd_buf;
  assign cmd_w  = bus_sel && bus_wr && (bus_addr == 5'h04);
  assign rd_buf = bus_sel && !bus_wr && (bus_addr == 5'h14);

  p_done_from_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_done) |-> $past(busy));

  p_clr_err_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && bus_wdata[5]) |=> (!stat_err && !test_done && !seed_done));

  p_clr_int_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && bus_wdata[4] && !bus_wdata[5] && stat_err)
      |=> ((test_done || !$past(test_done)) && (seed_done || !$past(seed_done))));

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_done && mask_err) |-> !irq);

  p_err_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_err && !mask_err) |-> irq);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && fifo_count == '0) |-> (bus_rdata == 32'h0));

  p_err_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_err |=> (fifo_count <= $past(fifo_count)));
endmodule

bind rng_ctl rng_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .fifo_count (fifo_count),
  .busy       (busy),
  .test_done  (test_done),
  .seed_done  (seed_done),
  .stat_err   (stat_err),
  .mask_done  (mask_done),
  .mask_err   (mask_err)
);

// File: tb/rng_ctl_test.sv
module rng_ctl_test;
  localparam int PERIOD = 10;
  localparam int OPC    = 64;
  localparam logic [31:0] SEED = 32'h2545F491;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, force_fail = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  rng_ctl #(.OP_CYCLES(OPC), .SEED_INIT(SEED)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .force_fail(force_fail), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  // vector: kind[102:101] addr[100:96] data[95:64] mask[63:32] exp[31:0]
  // kind 0 write, 1 read+check (data = requirement number), 2 idle data cycles, 3 irq check
  function automatic logic [102:0] v_wr(input logic [4:0] a, input logic [31:0] d);
    return {2'd0, a, d, 32'h0, 32'h0};
  endfunction
  function automatic logic [102:0] v_rd(input logic [4:0] a, input logic [31:0] m,
                                        input logic [31:0] e, input int r);
    return {2'd1, a, 32'(r), m, e};
  endfunction
  function automatic logic [102:0] v_idle(input int n);
    return {2'd2, 5'h0, 32'(n), 32'h0, 32'h0};
  endfunction
  function automatic logic [102:0] v_irq(input logic e, input int r);
    return {2'd3, 5'h0, 32'(r), 32'h1, {31'h0, e}};
  endfunction

  localparam int NV = 28;
  localparam logic [102:0] VEC [NV] = '{
    v_rd(5'h0C, 32'hFFFFFFFF, 32'h0, 1),      // R1 status clear
    v_rd(5'h08, 32'hFFFFFFFF, 32'h0, 1),      // R1 control clear
    v_rd(5'h10, 32'hFFFFFFFF, 32'h0, 1),      // R1 error clear
    v_irq(1'b0, 1),                           // R1 irq low
    v_rd(5'h14, 32'hFFFFFFFF, 32'h0, 9),      // R9 empty read
    v_rd(5'h0C, 32'h00000F00, 32'h0, 9),      // R9 level still 0
    v_wr(5'h08, 32'h60),
    v_rd(5'h08, 32'hFFFFFFFF, 32'h60, 2),     // R2 control read-back
    v_wr(5'h08, 32'h0),
    v_wr(5'h04, 32'h3),                       // R3 both starts: self-test wins
    v_idle(70),
    v_rd(5'h0C, 32'h00010F30, 32'h10, 3),     // R3 only test done
    v_irq(1'b1, 5),                           // R5
    v_rd(5'h04, 32'hFFFFFFFF, 32'h0, 2),      // R2 command reads 0
    v_wr(5'h04, 32'h10),
    v_rd(5'h0C, 32'hFFFFFFFF, 32'h0, 4),      // R4 clear-int without error
    v_irq(1'b0, 4),
    v_wr(5'h04, 32'h2),                       // seed
    v_wr(5'h04, 32'h1),                       // R11 ignored while busy
    v_idle(90),
    v_rd(5'h0C, 32'h00010F30, 32'h0F20, 7),   // R6 R7 R11 level 15, seed done only
    v_wr(5'h08, 32'h20),
    v_irq(1'b0, 5),                           // R5 done masked
    v_wr(5'h08, 32'h0),
    v_irq(1'b1, 5),
    v_wr(5'h04, 32'h10),
    v_irq(1'b0, 4),
    v_rd(5'h0C, 32'h00010F30, 32'h0F00, 6)    // R6 level stays saturated
  };

  function automatic logic [31:0] ref_xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  task automatic check(input int r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d got %h expected %h", r, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic [31:0] m,
                          input logic [31:0] e, input int r);
    logic [31:0] got;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #(PERIOD/4) got = bus_rdata;
    check(r, got & m, e & m);
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic irq_chk(input logic e, input int r);
    @(negedge clk);
    #(PERIOD/4) check(r, {31'h0, irq}, {31'h0, e});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] x;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][102:101])
        2'd0: bus_write(VEC[i][100:96], VEC[i][95:64]);
        2'd1: bus_read(VEC[i][100:96], VEC[i][63:32], VEC[i][31:0], int'(VEC[i][95:64]));
        2'd2: repeat (int'(VEC[i][95:64])) @(posedge clk);
        default: irq_chk(VEC[i][0], int'(VEC[i][95:64]));
      endcase
    end

    // R3 exact completion edge, then R8 word order from reset seed
    do_reset();
    bus_write(5'h04, 32'h2);
    repeat (OPC - 1) @(posedge clk);
    bus_read(5'h0C, 32'h20, 32'h0, 3);
    bus_read(5'h0C, 32'h20, 32'h20, 3);
    repeat (30) @(posedge clk);
    x = SEED;
    for (int k = 0; k < 20; k++) begin
      x = ref_xs(x);
      bus_read(5'h14, 32'hFFFFFFFF, x, 8);   // R8
    end

    // R10 forced failure on a seed, then R4/R5 with an error present
    do_reset();
    force_fail = 1'b1;
    bus_write(5'h04, 32'h2);
    repeat (OPC + 4) @(posedge clk);
    force_fail = 1'b0;
    bus_read(5'h10, 32'hFFFFFFFF, 32'h8, 10);           // R10 error bit 3
    repeat (20) @(posedge clk);
    bus_read(5'h0C, 32'h00010F30, 32'h00010020, 10);    // R10 no generation
    irq_chk(1'b1, 5);
    bus_write(5'h08, 32'h20);
    irq_chk(1'b1, 5);                                   // R5 error unmasked
    bus_write(5'h08, 32'h60);
    irq_chk(1'b0, 5);                                   // R5 both masked
    bus_write(5'h08, 32'h0);
    bus_write(5'h04, 32'h10);
    bus_read(5'h0C, 32'h00010F30, 32'h00010020, 4);     // R4 clear-int blocked
    bus_write(5'h04, 32'h20);
    bus_read(5'h0C, 32'hFFFFFFFF, 32'h0, 4);            // R4 clear-err
    bus_read(5'h10, 32'hFFFFFFFF, 32'h0, 4);
    irq_chk(1'b0, 4);
    bus_write(5'h04, 32'h2);
    repeat (OPC + 25) @(posedge clk);
    bus_read(5'h0C, 32'h00010F00, 32'h0F00, 7);         // R7 reseed fills

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule